// File: doc/BRIEF.md
# Programmable Down-Counter Timer with Prescaler

This block is an 8-bit timer that counts down from a value loaded by software. A 7-bit binary prescaler sits in front of the counter. A 3-bit select field picks one of its taps, so the counter steps once every 1, 2, 4, up to 128 source ticks. Two source bits choose what feeds the prescaler:

- the core clock, one tick per cycle;
- rising edges of an external pin;
- the core clock, counted only while the external pin is high.

The pin passes through a two-flop synchronizer and an edge detector before it is used.

When the counter steps down to zero, a sticky flag is set. The counter does not stop at zero. It wraps to 0xFF and keeps counting, so software can measure how much time has passed since the flag rose. The interrupt request output is the flag, qualified by a mask bit in the control register and by a global interrupt-disable input. Software reaches the block through a small register bus with two addresses: control/status and counter. A write-only bit clears the prescaler, so a new measurement can start on a clean prescaler phase.

Top module: `cdtimer_top`

## Requirements
- R1: While reset is held, the control register reads 0x40 (masked, flag clear, internal source, divide by 1) and the counter reads 0xFF.
- R2: The control register sits at address 0 and the counter at address 1. Control bit fields:
  - bit 7: flag
  - bit 6: mask (1 = masked)
  - bits 5:4: source (00 internal, 01 external rising edge, 10 or 11 gated)
  - bit 3: prescaler clear
  - bits 2:0: divide select
- R3: After a prescaler clear, the counter steps down by exactly one for every 2^select source ticks, and does not step on fewer.
- R4: The flag is set when the counter steps from 1 to 0. The counter then wraps from 0x00 to 0xFF and keeps counting.
- R5: The flag stays set until a control write with bit 7 equal to 0. A control write with bit 7 equal to 1 leaves the flag unchanged.
- R6: irq_req is high only when the flag is set, the mask bit is 0 and irq_disable is 0.
- R7: A counter write loads the written value and clears the flag, so a pending request is dropped.
- R8: Writing 1 to control bit 3 zeroes the prescaler, and bit 3 always reads back as 0.
- R9: With source 00, the prescaler gets one tick per clock cycle.
- R10: With source 01, each rising edge of ext_clk gives exactly one tick. A pin held high or held low gives no further ticks.
- R11: With source 10 or 11, one tick is given per clock cycle while the synchronized pin is high, and none while it is low.
- R12: Reading either register has no side effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control/status, 1 = counter |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| ext_clk | input | 1 | External clock or gate pin, asynchronous |
| irq_disable | input | 1 | Global interrupt disable |
| irq_req | output | 1 | Interrupt request level |

## Verification
A wrong prescaler phase or a wrong tap shows up in the counter readback as soon as the pulse count crosses a multiple of 2^select. The bench drives counted external pulses for every select value and checks the count both exactly at a tap boundary and one pulse short of the next.

A fault in the synchronizer or the gating shows up as a counter difference over a known window, a few cycles after the pin changes. The windows are sized so the expected difference is exact whatever the starting phase.

Flag and request faults show up on irq_req, and in control bit 7, in the same cycle as the terminal step or the register write that follows it.

// File: rtl/cdtimer_pkg.sv
// Package: shared constants and types for the down-counter timer.
// Assumes an 8-bit register bus; field positions are fixed by the control layout.
package cdtimer_pkg;
    localparam int SEL_W      = 3;
    localparam int CTRL_W     = 8;
    localparam int BIT_FLAG   = 7;
    localparam int BIT_MASK   = 6;
    localparam int BIT_SRC_HI = 5;
    localparam int BIT_SRC_LO = 4;
    localparam int BIT_PCLR   = 3;

    typedef enum logic [1:0] {
        SRC_CORE  = 2'b00,
        SRC_PIN   = 2'b01,
        SRC_GATE  = 2'b10,
        SRC_GATE2 = 2'b11
    } tick_src_e;
endpackage

// File: rtl/cdt_clksel.sv
// Module: source selector. Synchronizes the external pin, detects its rising
// edge and produces a one-cycle source tick according to the source field.
// Assumes ext_pin is asynchronous to clk; SYNC_STAGES >= 2.
module cdt_clksel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ext_pin,
    input  cdtimer_pkg::tick_src_e src,
    output logic                  tick_src
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   pin_s;
    logic                   pin_rise;

    // Synchronizer chain: one flop per stage, the first fed by the pin.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= ext_pin;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    // Edge history: remembers the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= pin_s;
    end

    assign pin_rise = pin_s & ~last_q;

    // Source mux: internal, pin edge, or internal gated by pin level.
    always_comb begin
        unique case (src)
            cdtimer_pkg::SRC_CORE: tick_src = 1'b1;
            cdtimer_pkg::SRC_PIN:  tick_src = pin_rise;
            default:               tick_src = pin_s;
        endcase
    end
endmodule

// File: rtl/cdt_prescaler.sv
// Module: binary prescaler. Counts source ticks and emits a divided tick on the
// source tick at which the low 'sel' bits of the count are all ones.
// Assumes sel <= PRE_W; a clear has priority over counting.
module cdt_prescaler #(
    parameter int PRE_W = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_out
);
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] tap_mask;

    // Tap mask: ones in the low 'sel' positions.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            tap_mask[i] = (i < int'(sel));
        end
    end

    assign tick_out = tick_in && ((div_q & tap_mask) == tap_mask);

    // Divider register: zeroed by clear, else advanced on each source tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_q <= '0;
        else if (clr)     div_q <= '0;
        else if (tick_in) div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/cdt_downcnt.sv
// Module: down counter with terminal flag. Loads on write, steps on tick,
// wraps through zero and sets a sticky flag on the 1 -> 0 step.
// Assumes load has priority over a tick; a flag set wins over a flag clear.
module cdt_downcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic hit_zero;

    assign hit_zero = tick && (cnt == CNT_ONE);

    // Count register: preset by software, else decremented per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '1;
        else if (load) cnt <= load_val;
        else if (tick) cnt <= cnt - 1'b1;
    end

    // Terminal flag: cleared by a load, set on reaching zero, else clearable.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (load)     flag <= 1'b0;
        else if (hit_zero) flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/cdtimer_top.sv
// Module: programmable down-counter timer top. Decodes the register bus,
// holds the control fields and combines flag, mask and global disable into irq_req.
// Assumes CNT_W >= 8 so the control byte fits the bus; reads have no side effect.
module cdtimer_top #(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             ext_clk,
    input  logic             irq_disable,
    output logic             irq_req
);
    import cdtimer_pkg::*;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_CNT  = 1'b1;

    logic             ctrl_wr;
    logic             cnt_wr;
    logic [SEL_W-1:0] sel_q;
    tick_src_e        src_q;
    logic             mask_q;
    logic             pclr;
    logic             flag_clr;
    logic             tick_src;
    logic             tick_div;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic [CTRL_W-1:0] ctrl_rd;

    assign ctrl_wr  = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
    assign cnt_wr   = bus_sel && bus_wr && (bus_addr == ADDR_CNT);
    assign pclr     = ctrl_wr && bus_wdata[BIT_PCLR];
    assign flag_clr = ctrl_wr && !bus_wdata[BIT_FLAG];

    // Control fields: select, source and mask, written at the control address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            src_q  <= SRC_CORE;
            mask_q <= 1'b1;
        end else if (ctrl_wr) begin
            sel_q  <= bus_wdata[SEL_W-1:0];
            src_q  <= tick_src_e'(bus_wdata[BIT_SRC_HI:BIT_SRC_LO]);
            mask_q <= bus_wdata[BIT_MASK];
        end
    end

    cdt_clksel #(.SYNC_STAGES(SYNC_STAGES)) clksel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_pin  (ext_clk),
        .src      (src_q),
        .tick_src (tick_src)
    );

    cdt_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) presc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (tick_src),
        .clr      (pclr),
        .sel      (sel_q),
        .tick_out (tick_div)
    );

    cdt_downcnt #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_div),
        .load     (cnt_wr),
        .load_val (bus_wdata),
        .flag_clr (flag_clr),
        .cnt      (cnt_q),
        .flag     (flag_q)
    );

    // Control readback: clear bit always returns zero.
    always_comb begin
        ctrl_rd                        = '0;
        ctrl_rd[SEL_W-1:0]             = sel_q;
        ctrl_rd[BIT_SRC_HI:BIT_SRC_LO] = src_q;
        ctrl_rd[BIT_MASK]              = mask_q;
        ctrl_rd[BIT_FLAG]              = flag_q;
    end

    // Read mux: pure selection, no side effects.
    assign bus_rdata = (bus_addr == ADDR_CNT) ? cnt_q : CNT_W'(ctrl_rd);

    assign irq_req = flag_q && !mask_q && !irq_disable;
endmodule

// File: rtl/cdtimer_chk.sv
// Module: property checker for cdtimer_top, bound to every instance.
// Assumes the top's internal names tick_div, cnt_q and flag_q.
module cdtimer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic [CNT_W-1:0] bus_rdata,
    input logic             irq_disable,
    input logic             irq_req,
    input logic             tick_div,
    input logic [CNT_W-1:0] cnt_q,
    input logic             flag_q
);
    logic wr_cnt;
    logic wr_ctl_clr;

    assign wr_cnt     = bus_sel && bus_wr && bus_addr;
    assign wr_ctl_clr = bus_sel && bus_wr && !bus_addr && !bus_wdata[7];

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_div && !wr_cnt) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_div && !wr_cnt) |=> $stable(cnt_q));

    a_r4_flag_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_div && !wr_cnt && cnt_q == CNT_W'(1)) |=> flag_q);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !wr_cnt && !wr_ctl_clr) |=> flag_q);

    a_r6_irq_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_disable || !flag_q) |-> !irq_req);

    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q == $past(bus_wdata) && !flag_q));

    a_r8_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr |-> !bus_rdata[3]);
endmodule

bind cdtimer_top cdtimer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_disable (irq_disable),
    .irq_req     (irq_req),
    .tick_div    (tick_div),
    .cnt_q       (cnt_q),
    .flag_q      (flag_q)
);

// File: tb/cdtimer_top_tb_top.sv
// Bench: sweeps every divide select with counted pin pulses, then checks
// flag, request, load, internal and gated counting against arithmetic.
module cdtimer_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;
    logic       irq_disable = 1'b0;
    logic       irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cdtimer_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk(ext_clk), .irq_disable(irq_disable), .irq_req(irq_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ext_clk = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, c0, c1;
        // R1: reset values while reset held
        repeat (3) @(negedge clk);
        bus_read(1'b0, v); check(v == 8'h40, "R1 ctrl reset", v, 8'h40);
        bus_read(1'b1, v); check(v == 8'hFF, "R1 counter reset", v, 8'hFF);
        @(negedge clk); rst_n = 1'b1;

        // R8 / R2: external source, clear prescaler, clear bit reads 0
        bus_write(1'b0, 8'h58);
        bus_read(1'b0, v); check(v == 8'h50, "R8 clear bit reads zero", v, 8'h50);

        // R3 / R10: sweep every divide select with counted pulses
        for (int s = 0; s < 8; s++) begin
            bus_write(1'b0, 8'h58 | 8'(s));
            bus_write(1'b1, 8'd200);
            pulses(3 << s);
            bus_read(1'b1, v); check(v == 8'd197, $sformatf("R3 sel=%0d at boundary", s), v, 197);
            if (s > 0) begin
                pulses((1 << s) - 1);
                bus_read(1'b1, v); check(v == 8'd197, $sformatf("R3 sel=%0d short of tap", s), v, 197);
            end
        end

        // R12: repeated reads leave the count unchanged
        bus_write(1'b0, 8'h58);
        bus_read(1'b1, c0);
        for (int k = 0; k < 10; k++) bus_read(1'b0, v);
        for (int k = 0; k < 10; k++) bus_read(1'b1, v);
        check(v == c0, "R12 reads no side effect", v, c0);

        // R10: pin held high gives a single tick
        @(negedge clk); ext_clk = 1'b1;
        repeat (20) @(negedge clk);
        bus_read(1'b1, v); check(v == c0 - 8'd1, "R10 held-high one tick", v, c0 - 8'd1);
        ext_clk = 1'b0; repeat (5) @(negedge clk);
        bus_read(1'b1, v); check(v == c0 - 8'd1, "R10 low gives none", v, c0 - 8'd1);

        // R4 / R6: reach zero with mask clear
        bus_write(1'b0, 8'h18);
        bus_write(1'b1, 8'd2);
        pulses(1);
        check(irq_req == 1'b0, "R6 no irq before zero", irq_req, 0);
        pulses(1);
        bus_read(1'b0, v); check(v == 8'h90, "R4 flag set at zero", v, 8'h90);
        check(irq_req == 1'b1, "R6 irq asserted", irq_req, 1);
        pulses(1);
        bus_read(1'b1, v); check(v == 8'hFF, "R4 wraps to FF", v, 8'hFF);
        bus_read(1'b0, v); check(v[7] == 1'b1, "R5 flag stays after wrap", v[7], 1);
        @(negedge clk); irq_disable = 1'b1;
        #1 check(irq_req == 1'b0, "R6 global disable", irq_req, 0);
        @(negedge clk); irq_disable = 1'b0;
        #1 check(irq_req == 1'b1, "R6 disable released", irq_req, 1);

        // R5 / R6: mask and write-one keep the flag
        bus_write(1'b0, 8'hD0);
        bus_read(1'b0, v); check(v == 8'hD0, "R5 write-one keeps flag", v, 8'hD0);
        check(irq_req == 1'b0, "R6 masked", irq_req, 0);
        bus_write(1'b0, 8'h90);
        check(irq_req == 1'b1, "R6 unmasked", irq_req, 1);
        bus_write(1'b0, 8'h10);
        bus_read(1'b0, v); check(v == 8'h10, "R5 write-zero clears flag", v, 8'h10);
        check(irq_req == 1'b0, "R5 irq gone", irq_req, 0);

        // R7: counter write drops a pending request
        bus_write(1'b1, 8'd1);
        pulses(1);
        check(irq_req == 1'b1, "R7 pending set", irq_req, 1);
        bus_write(1'b1, 8'h33);
        check(irq_req == 1'b0, "R7 pending lost", irq_req, 0);
        bus_read(1'b1, v); check(v == 8'h33, "R7 load value", v, 8'h33);
        bus_read(1'b0, v); check(v[7] == 1'b0, "R7 flag cleared", v[7], 0);

        // R9: internal source, divide 1 and divide 4
        bus_write(1'b0, 8'h48);
        bus_read(1'b1, c0);
        repeat (36) @(negedge clk);
        bus_read(1'b1, c1); check(8'(c0 - c1) == 8'd37, "R9 div1 ticks", 8'(c0 - c1), 37);
        bus_write(1'b0, 8'h4A);
        bus_read(1'b1, c0);
        repeat (39) @(negedge clk);
        bus_read(1'b1, c1); check(8'(c0 - c1) == 8'd10, "R9 div4 ticks", 8'(c0 - c1), 10);

        // R11: gated source, both encodings
        for (int g = 0; g < 2; g++) begin
            bus_write(1'b0, g == 0 ? 8'h68 : 8'h78);
            bus_read(1'b1, c0);
            repeat (20) @(negedge clk);
            bus_read(1'b1, c1); check(c1 == c0, "R11 gate low holds", c1, c0);
            ext_clk = 1'b1;
            repeat (25) @(negedge clk);
            ext_clk = 1'b0;
            repeat (10) @(negedge clk);
            bus_read(1'b1, v); check(8'(c1 - v) == 8'd25, "R11 gated ticks", 8'(c1 - v), 25);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule